// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block connects a synchronous request/response port to an 8-bit asynchronous static memory. It takes one read or write at a time through a valid/ready handshake. It then drives a 15-bit address, three active-low strobes (chip select, output enable and write strobe) and a split bidirectional data path made of an output value, a driver enable and an input.

Every timing limit of the memory is given as a parameter in nanoseconds. Each limit becomes a whole number of clock cycles, rounded up, with a floor of one cycle. The controller places every strobe edge, data capture and driver switch on those counts:

- A read holds its strobes long enough for both the cycle time and the slower of the two access delays.
- A write keeps the output enable high for its whole length.
- A write that follows a read waits until the memory has stopped driving the data lines.

All bus outputs come from registers.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is high and after it is released, all three strobes are high, the data driver is off, the response valid is low and the request ready is high.
- R2: The request ready is high only while the controller is idle. A request is taken on a clock edge where valid and ready are both high. On that same edge the address appears on the bus. For a read (write flag 0), chip select and output enable fall on that edge.
- R3: A read keeps chip select and output enable low for exactly N_RD cycles, where N_RD is the largest of the cycle counts for read cycle time, address access and output-enable access. Both strobes rise together on the edge that returns the controller to idle.
- R4: Read data is taken from the input on the N_ACC-th edge after the read strobes fall. N_ACC is the larger of the address-access and output-enable-access counts. It is presented with a response valid that lasts exactly one cycle.
- R5: During a write, output enable stays high. Chip select and the write strobe fall together and stay low for exactly N_W cycles, where N_W is the larger of the write-pulse and data-setup counts. The write data is driven for that whole time.
- R6: After the write strobe rises, the data driver and the address are held for N_WH cycles, where N_WH is the larger of the data-hold and address-hold counts. The driver is then switched off and the controller returns to idle.
- R7: A write that starts after a read neither drives data nor lowers its strobes until at least N_TA edges after the read strobes rose. N_TA is the larger of the output-release and write-strobe-release counts. While it waits, the write shows its address with all strobes high.
- R8: Each count is the timing value in nanoseconds divided by the clock period, rounded up, and never less than one.
- R9: The address stays constant from the edge that takes a request until the controller is idle again.
- R10: Between two back-to-back read cycles, chip select and output enable are high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Data value to drive |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Data value read from the bus |

## Verification
With the default parameters, the read data capture and the end of the read cycle land on the same edge. On that edge the response pulse, the rising strobes and the return of ready all appear together. The bench follows such a read at once with a write, which runs into the turnaround guard. It also repeats the read-to-write case with the write offered one, two and then many cycles later. A per-cycle expected waveform, built from the counts in the requirements, judges every case. A memory model in the bench adds two checks: it returns valid data only once the access time in nanoseconds has passed, and it reports any driver enable that overlaps the memory's own drive window.

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl #(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int CLK_NS      = 4,
  parameter int T_CYC_RD_NS = 35,
  parameter int T_ACC_A_NS  = 35,
  parameter int T_ACC_OE_NS = 15,
  parameter int T_REL_NS    = 13,
  parameter int T_WREL_NS   = 13,
  parameter int T_WPW_NS    = 25,
  parameter int T_SU_NS     = 15,
  parameter int T_DHLD_NS   = 0,
  parameter int T_AHLD_NS   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  function automatic int ncyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_RC   = ncyc(T_CYC_RD_NS);
  localparam int N_AA   = ncyc(T_ACC_A_NS);
  localparam int N_OA   = ncyc(T_ACC_OE_NS);
  localparam int N_ACC  = (N_AA > N_OA) ? N_AA : N_OA;
  localparam int N_RD   = (N_RC > N_ACC) ? N_RC : N_ACC;
  localparam int N_HZ   = ncyc(T_REL_NS);
  localparam int N_WZ   = ncyc(T_WREL_NS);
  localparam int N_TA   = (N_HZ > N_WZ) ? N_HZ : N_WZ;
  localparam int N_WP   = ncyc(T_WPW_NS);
  localparam int N_DS   = ncyc(T_SU_NS);
  localparam int N_W    = (N_WP > N_DS) ? N_WP : N_DS;
  localparam int N_DH   = ncyc(T_DHLD_NS);
  localparam int N_AH   = ncyc(T_AHLD_NS);
  localparam int N_WH   = (N_DH > N_AH) ? N_DH : N_AH;
  localparam int M1     = (N_RD > N_W) ? N_RD : N_W;
  localparam int M2     = (N_TA > N_WH) ? N_TA : N_WH;
  localparam int MAXC   = (M1 > M2) ? M1 : M2;
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TA, S_WR, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] turn;
  logic          turn_ok;

  assign req_ready = (st == S_IDLE);
  assign turn_ok   = (turn < CW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      turn       <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (turn != '0) turn <= turn - 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          cnt      <= '0;
          if (req_we) begin
            mem_dq_out <= req_wdata;
            if (turn_ok) begin
              mem_ce_n  <= 1'b0;
              mem_we_n  <= 1'b0;
              mem_dq_oe <= 1'b1;
              st        <= S_WR;
            end else begin
              st <= S_TA;
            end
          end else begin
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            st       <= S_RD;
          end
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N_ACC - 1)) begin
            rsp_rdata <= mem_dq_in;
            rsp_valid <= 1'b1;
          end
          if (cnt == CW'(N_RD - 1)) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            turn     <= CW'(N_TA);
            st       <= S_IDLE;
          end
        end
        S_TA: if (turn_ok) begin
          mem_ce_n  <= 1'b0;
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          cnt       <= '0;
          st        <= S_WR;
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N_W - 1)) begin
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            cnt      <= '0;
            st       <= S_HOLD;
          end
        end
        S_HOLD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N_WH - 1)) begin
            mem_dq_oe <= 1'b0;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
`timescale 1ns/1ps
module sram_bus_ctrl_chk #(
  parameter int AW   = 15,
  parameter int N_TA = 4,
  parameter int N_W  = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic          rsp_valid
);
  localparam int SAT = 1000;
  int gap;
  int wlow;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= SAT;
      wlow <= 0;
    end else begin
      if (!mem_oe_n) gap <= 0;
      else if (gap < SAT) gap <= gap + 1;
      if (!mem_we_n) wlow <= (wlow < SAT) ? wlow + 1 : wlow;
      else wlow <= 0;
    end
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!mem_oe_n && !mem_we_n)); // R5
  AST_DRV_OE_HIGH: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> mem_oe_n); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(mem_we_n) |-> (wlow == N_W)); // R5
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst) $rose(mem_dq_oe) |-> (gap >= N_TA)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R4
  AST_RD_READY: assert property (@(posedge clk) disable iff (rst) !mem_oe_n |-> !req_ready); // R2
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.AW(AW), .N_TA(N_TA), .N_W(N_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid)
);

// File: tb/sim_sram_bus_ctrl.sv
`timescale 1ns/100ps
module sim_sram_bus_ctrl;
  localparam int PER = 4;
  function automatic int cc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int NACC = (cc(35) > cc(15)) ? cc(35) : cc(15);
  localparam int NRD  = (cc(35) > NACC) ? cc(35) : NACC;
  localparam int NTA  = cc(13);
  localparam int NW   = (cc(25) > cc(15)) ? cc(25) : cc(15);
  localparam int NWH  = cc(0);

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_we = 0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h00;
  logic [14:0] mem_addr;

  sram_bus_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #2 clk = ~clk;

  int nvec = 0, nfail = 0, since = 1000;
  logic [7:0] mem [logic [14:0]];
  logic [7:0] shadow [logic [14:0]];

  function automatic logic [7:0] dflt(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  task automatic fail(input string tag, input string what, input int got, input int exp);
    nfail++;
    $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
  endtask

  // memory model: data valid 35 ns after access starts, drives 13 ns after release
  logic act, p_act = 0, p_we = 1, p_ce = 1, p_doe = 0;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dout = '0;
  realtime t_act = 0, t_rel = -100;
  initial begin
    #0.5;
    forever begin
      act = !rst && !mem_ce_n && !mem_oe_n;
      if (act && (!p_act || mem_addr != p_addr)) t_act = $realtime;
      if (!act && p_act) t_rel = $realtime;
      if (act && ($realtime - t_act) >= 35.0)
        mem_dq_in = mem.exists(mem_addr) ? mem[mem_addr] : dflt(mem_addr);
      else
        mem_dq_in = ~(mem.exists(mem_addr) ? mem[mem_addr] : dflt(mem_addr));
      if (!rst && mem_dq_oe && (act || ($realtime - t_rel) < 13.0)) begin
        nvec++;
        fail("R7", "bus contention at ns", int'($realtime), 0);
      end
      if (!rst && !p_we && mem_we_n && !p_ce) begin
        nvec++;
        if (!p_doe || !mem_dq_oe) fail("R6", "driver at write end", mem_dq_oe, 1);
        else mem[p_addr] = p_dout;
      end
      p_act = act; p_we = mem_we_n; p_ce = mem_ce_n;
      p_doe = mem_dq_oe; p_addr = mem_addr; p_dout = mem_dq_out;
      #1;
    end
  end

  logic e_rdy, e_ce, e_oe, e_we, e_doe, e_rv;
  logic [14:0] e_addr = '0;
  logic [7:0]  e_dout, e_rdata;

  task automatic expv(input logic rdy, ce, oe, we, doe, rv,
                      input logic [14:0] a, input logic [7:0] d, r);
    e_rdy = rdy; e_ce = ce; e_oe = oe; e_we = we; e_doe = doe; e_rv = rv;
    e_addr = a; e_dout = d; e_rdata = r;
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    since++;
    nvec++;
    if (req_ready !== e_rdy) fail(tag, "ready", req_ready, e_rdy);
    if (mem_ce_n !== e_ce) fail(tag, "ce_n", mem_ce_n, e_ce);
    if (mem_oe_n !== e_oe) fail(tag, "oe_n", mem_oe_n, e_oe);
    if (mem_we_n !== e_we) fail(tag, "we_n", mem_we_n, e_we);
    if (mem_dq_oe !== e_doe) fail(tag, "dq_oe", mem_dq_oe, e_doe);
    if (rsp_valid !== e_rv) fail(tag, "rsp_valid", rsp_valid, e_rv);
    if (mem_addr !== e_addr) fail(tag, "addr", mem_addr, e_addr);
    if (e_doe && mem_dq_out !== e_dout) fail(tag, "dq_out", mem_dq_out, e_dout);
    if (e_rv && rsp_rdata !== e_rdata) fail(tag, "rdata", rsp_rdata, e_rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      expv(1, 1, 1, 1, 0, 0, e_addr, 0, 0);
      step("R2");
    end
  endtask

  task automatic rd(input logic [14:0] a);
    logic [7:0] d;
    d = shadow.exists(a) ? shadow[a] : dflt(a);
    req_valid = 1; req_we = 0; req_addr = a;
    expv(0, 0, 0, 1, 0, 0, a, 0, 0);
    step("R2");
    req_valid = 0;
    for (int k = 1; k <= NRD; k++) begin
      logic fin;
      fin = (k == NRD);
      expv(fin, fin, fin, 1, 0, k == NACC, a, 0, d);
      if (k == NACC) step("R4");
      else if (fin) step("R10");
      else step("R3");
    end
    since = 0;
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    logic started;
    started = 0;
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    while (!started) begin
      if (since + 1 >= NTA) begin
        expv(0, 0, 1, 0, 1, 0, a, d, 0);
        started = 1;
        step("R5");
      end else begin
        expv(0, 1, 1, 1, 0, 0, a, d, 0);
        step("R7");
      end
      req_valid = 0;
    end
    for (int k = 1; k < NW; k++) begin
      expv(0, 0, 1, 0, 1, 0, a, d, 0);
      step("R5");
    end
    for (int k = NW; k <= NW + NWH; k++) begin
      if (k == NW + NWH) expv(1, 1, 1, 1, 0, 0, a, d, 0);
      else expv(0, 1, 1, 1, 1, 0, a, d, 0);
      step("R6");
    end
    shadow[a] = d;
  endtask

  initial begin
    #(200000 * PER);
    fail("WD", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    // R8: cycle counts follow ceil(ns/period) with a one-cycle floor
    nvec++;
    if (NACC != 9 || NRD != 9 || NTA != 4 || NW != 7 || NWH != 1)
      fail("R8", "derived counts", NACC * 10000 + NTA * 100 + NW, 90407);
    expv(1, 1, 1, 1, 0, 0, 15'h0, 0, 0);
    step("R1");
    step("R1");
    rst = 0;
    step("R1");
    idle(2);
    rd(15'h0000);
    rd(15'h7FFF);
    wr(15'h1234, 8'h5A);
    rd(15'h1234);
    idle(1);
    wr(15'h7FFF, 8'hC3);
    rd(15'h0555);
    idle(2);
    wr(15'h0001, 8'h00);
    wr(15'h0002, 8'h81);
    idle(5);
    rd(15'h7FFF);
    idle(6);
    wr(15'h2AAA, 8'hFF);
    rd(15'h0001);
    rd(15'h2AAA);
    rd(15'h0002);
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule